// File: doc/BRIEF.md
# Programmable Interrupt Steering Router

This block gathers the interrupt requests of a system and presents them as one vector of legacy IRQ lines to a pair of cascaded interrupt controllers. Three requests can be steered. Two of them are shared, PCI-style requests that assert low. The third is an on-board request that asserts high. Each steerable source has its own 8-bit routing register. The register either names one of eleven permitted IRQ numbers or turns routing off for that source.

Directly wired legacy IRQ pins also pass through the block. They are merged with the steered requests by a logical OR, after every source has been brought to an active-high sense. Legacy line 8 keeps its active-low sense at both the input and the output. The routing registers are loaded through a simple write port: an enable, a source select and a data byte. The output vector is purely combinational from the pins and the registers.

Top module: `irq_steer_router`

## Requirements
- R1: After reset, every routing register holds 0x80 (routing off). Asserted steerable sources then change no output line, and the output shows only the legacy pass-through (0x0100 when the legacy pins are idle).
- R2: A shared request (pirq_n bit 0 or bit 1) is asserted when its pin is low. When its register holds a permitted number N with bit 7 clear, output bit N is 1 while the pin is low and 0 when it is high. The permitted numbers are 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15.
- R3: The on-board request (mirq) is asserted when high. It steers to the same permitted numbers in the same way as the shared requests.
- R4: When bit 7 of a routing register is 1, that source drives no output line, whatever value bits 3:0 hold.
- R5: A destination number of 0, 1, 2, 8 or 13 in bits 3:0 acts as routing off. No output line is driven by that source.
- R6: Only bits 3:0 select the destination. Bits 6:4 have no effect on routing.
- R7: Output line N is asserted when any steered source routed to N is asserted, or when legacy input N is asserted. The contributions are ORed.
- R8: Legacy inputs 1 to 7 and 9 to 15 are active high and appear on the same output bit. Output bit 0 is always 0, and input bit 0 is ignored.
- R9: Legacy line 8 is active low at both the input and the output. Output bit 8 follows input bit 8, because no source can be steered to line 8.
- R10: A write with wr_sel 0, 1 or 2 loads the register of shared source A, shared source B or the on-board source, in that order. A write with wr_sel 3 changes no register, and a write changes only the selected register.
- R11: A change on a request pin or a legacy pin reaches the output with no clock edge. A register write takes effect at the rising edge that samples wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the routing registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the routing registers |
| wr_sel | input | 2 | Register select: 0 = source A, 1 = source B, 2 = on-board source |
| wr_data | input | 8 | Routing byte: bit 7 = off, bits 3:0 = IRQ number |
| pirq_n | input | 2 | Shared interrupt requests, active low |
| mirq | input | 1 | On-board interrupt request, active high |
| isa_irq | input | 16 | Legacy IRQ pins; bit 8 active low, bit 0 unused |
| irq_out | output | 16 | Merged IRQ vector to the controllers; bit 8 active low |

## Verification
The bound checker watches several properties on every cycle. Output bit 0 must stay clear, and lines 8 and 13 must mirror their legacy inputs. Each asserted legacy input must show on its output line. When every source is switched off, the output must equal the pass-through alone. The routing state must hold across cycles without a valid write. The steering itself can only be shown by the bench's scenarios. These cover:
- each of the eleven destinations for each source;
- polarity per source;
- the reserved numbers and the ignored upper bits;
- several sources ORed onto one line;
- the same-cycle response to pins as against the edge-timed response to writes.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
   localparam int CFG_W     = 8;
   localparam int DIS_BIT   = 7;
   localparam int NUM_W     = 4;
   localparam logic [CFG_W-1:0] CFG_RESET = 8'h80;

   typedef logic [CFG_W-1:0] route_cfg_t;
endpackage

// File: rtl/irqr_route_reg.sv
module irqr_route_reg
   import irqr_pkg::*;
#(
   parameter int IDX   = 0,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  route_cfg_t       wr_data,
   output route_cfg_t       cfg_q
);
   localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

   logic hit;
   assign hit = wr_en && (wr_sel == MY_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
      end else if (hit) begin
         cfg_q <= wr_data;
      end
   end
endmodule

// File: rtl/irqr_decode.sv
module irqr_decode
   import irqr_pkg::*;
#(
   parameter int                    NUM_IRQ    = 16,
   parameter logic [NUM_IRQ-1:0]    LEGAL_MASK = 16'hDEF8
) (
   input  route_cfg_t            cfg,
   output logic [NUM_IRQ-1:0]    hit_vec
);
   logic             off;
   logic [NUM_W-1:0] num;

   assign off = cfg[DIS_BIT];
   assign num = cfg[NUM_W-1:0];

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      if (LEGAL_MASK[i]) begin : g_legal
         assign hit_vec[i] = !off && (num == NUM_W'(i));
      end else begin : g_reserved
         assign hit_vec[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irqr_polarity.sv
module irqr_polarity #(
   parameter int          N        = 3,
   parameter logic [N-1:0] LOW_MASK = '0
) (
   input  logic [N-1:0] raw,
   output logic [N-1:0] norm
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (LOW_MASK[i]) begin : g_inv
         assign norm[i] = ~raw[i];
      end else begin : g_buf
         assign norm[i] = raw[i];
      end
   end
endmodule

// File: rtl/irqr_merge.sv
module irqr_merge #(
   parameter int                 NUM_IRQ      = 16,
   parameter int                 NUM_SRC      = 3,
   parameter logic [NUM_IRQ-1:0] PASS_MASK    = 16'hFFFE,
   parameter logic [NUM_IRQ-1:0] ISA_LOW_MASK = 16'h0100
) (
   input  logic [NUM_SRC-1:0]              req,
   input  logic [NUM_SRC-1:0][NUM_IRQ-1:0] hits,
   input  logic [NUM_IRQ-1:0]              isa_raw,
   output logic [NUM_IRQ-1:0]              irq_out
);
   logic [NUM_IRQ-1:0] isa_norm;
   logic [NUM_IRQ-1:0] steer_or;
   logic [NUM_IRQ-1:0] comb;

   irqr_polarity #(.N(NUM_IRQ), .LOW_MASK(ISA_LOW_MASK)) u_isa_pol (
      .raw  (isa_raw),
      .norm (isa_norm)
   );

   always_comb begin
      steer_or = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (req[s]) begin
            steer_or = steer_or | hits[s];
         end
      end
   end

   assign comb = (steer_or | isa_norm) & PASS_MASK;

   irqr_polarity #(.N(NUM_IRQ), .LOW_MASK(ISA_LOW_MASK)) u_out_pol (
      .raw  (comb),
      .norm (irq_out)
   );
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
   import irqr_pkg::*;
#(
   parameter int                 NUM_IRQ      = 16,
   parameter int                 NUM_SHARED   = 2,
   parameter logic [NUM_IRQ-1:0] LEGAL_MASK   = 16'hDEF8,
   parameter logic [NUM_IRQ-1:0] PASS_MASK    = 16'hFFFE,
   parameter logic [NUM_IRQ-1:0] ISA_LOW_MASK = 16'h0100,
   localparam int                NUM_SRC      = NUM_SHARED + 1,
   localparam int                SEL_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [CFG_W-1:0]      wr_data,
   input  logic [NUM_SHARED-1:0] pirq_n,
   input  logic                  mirq,
   input  logic [NUM_IRQ-1:0]    isa_irq,
   output logic [NUM_IRQ-1:0]    irq_out
);
   localparam logic [NUM_SRC-1:0] SRC_LOW_MASK = {1'b0, {NUM_SHARED{1'b1}}};

   if (NUM_IRQ > (1 << NUM_W)) begin : g_chk_width
      $error("NUM_IRQ exceeds the destination field range");
   end
   if (NUM_SHARED < 1) begin : g_chk_shared
      $error("at least one shared source is required");
   end
   if ((LEGAL_MASK & ISA_LOW_MASK) != '0) begin : g_chk_pol
      $error("steering onto an active-low line is not supported");
   end
   if ((LEGAL_MASK & ~PASS_MASK) != '0) begin : g_chk_pass
      $error("a legal destination is masked from the output");
   end

   route_cfg_t [NUM_SRC-1:0]              cfg_q;
   logic       [NUM_SRC-1:0][NUM_IRQ-1:0] hits;
   logic       [NUM_SRC-1:0]              src_raw;
   logic       [NUM_SRC-1:0]              src_req;

   assign src_raw = {mirq, pirq_n};

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      irqr_route_reg #(.IDX(s), .SEL_W(SEL_W)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_sel  (wr_sel),
         .wr_data (wr_data),
         .cfg_q   (cfg_q[s])
      );
      irqr_decode #(.NUM_IRQ(NUM_IRQ), .LEGAL_MASK(LEGAL_MASK)) u_dec (
         .cfg     (cfg_q[s]),
         .hit_vec (hits[s])
      );
   end

   irqr_polarity #(.N(NUM_SRC), .LOW_MASK(SRC_LOW_MASK)) u_src_pol (
      .raw  (src_raw),
      .norm (src_req)
   );

   irqr_merge #(
      .NUM_IRQ      (NUM_IRQ),
      .NUM_SRC      (NUM_SRC),
      .PASS_MASK    (PASS_MASK),
      .ISA_LOW_MASK (ISA_LOW_MASK)
   ) u_merge (
      .req     (src_req),
      .hits    (hits),
      .isa_raw (isa_irq),
      .irq_out (irq_out)
   );
endmodule

// File: rtl/irq_steer_router_chk.sv
module irq_steer_router_chk
   import irqr_pkg::*;
#(
   parameter int                 NUM_IRQ      = 16,
   parameter int                 NUM_SRC      = 3,
   parameter int                 SEL_W        = 2,
   parameter logic [NUM_IRQ-1:0] LEGAL_MASK   = 16'hDEF8,
   parameter logic [NUM_IRQ-1:0] PASS_MASK    = 16'hFFFE,
   parameter logic [NUM_IRQ-1:0] ISA_LOW_MASK = 16'h0100
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic [SEL_W-1:0]               wr_sel,
   input logic [NUM_IRQ-1:0]             isa_irq,
   input logic [NUM_IRQ-1:0]             irq_out,
   input logic [NUM_SRC-1:0][CFG_W-1:0]  cfg_q
);
   logic [NUM_IRQ-1:0] isa_act;
   logic [NUM_IRQ-1:0] out_act;
   logic               all_off;
   logic               no_write;

   assign isa_act  = isa_irq ^ ISA_LOW_MASK;
   assign out_act  = irq_out ^ ISA_LOW_MASK;
   assign no_write = !wr_en || (32'(wr_sel) >= NUM_SRC);

   always_comb begin
      all_off = 1'b1;
      for (int s = 0; s < NUM_SRC; s++) begin
         all_off = all_off && cfg_q[s][DIS_BIT];
      end
   end

   assert_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out[0]);

   assert_irq8_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[8] == isa_irq[8]);

   assert_irq13_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[13] == isa_irq[13]);

   assert_isa_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((isa_act & PASS_MASK & ~out_act) == '0));

   assert_alloff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      all_off |-> (out_act == (isa_act & PASS_MASK)));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      no_write |=> $stable(cfg_q));
endmodule

bind irq_steer_router irq_steer_router_chk #(
   .NUM_IRQ      (NUM_IRQ),
   .NUM_SRC      (NUM_SRC),
   .SEL_W        (SEL_W),
   .LEGAL_MASK   (LEGAL_MASK),
   .PASS_MASK    (PASS_MASK),
   .ISA_LOW_MASK (ISA_LOW_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .isa_irq (isa_irq),
   .irq_out (irq_out),
   .cfg_q   (cfg_q)
);

// File: tb/irq_steer_router_bench.sv
`timescale 1ns/1ps
module irq_steer_router_bench;
   localparam logic [15:0] IDLE_ISA = 16'h0100;
   localparam logic [15:0] IDLE_OUT = 16'h0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [7:0]  wr_data = 8'h00;
   logic [1:0]  pirq_n = 2'b11;
   logic        mirq = 1'b0;
   logic [15:0] isa_irq = IDLE_ISA;
   logic [15:0] irq_out;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   int legal[11] = '{3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};
   int resv[5]   = '{0, 1, 2, 8, 13};

   always #2 clk = ~clk;

   irq_steer_router u_irq_steer_router (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .pirq_n  (pirq_n),
      .mirq    (mirq),
      .isa_irq (isa_irq),
      .irq_out (irq_out)
   );

   function automatic logic [15:0] bitv(int n);
      return 16'(1) << n;
   endfunction

   task automatic check(string req, logic [15:0] exp);
      #1;
      n_checks++;
      if (irq_out !== exp) begin
         n_errors++;
         $display("FAIL %s: irq_out=%h expected=%h", req, irq_out, exp);
      end
   endtask

   task automatic write_reg(logic [1:0] sel, logic [7:0] data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = data;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic idle_pins();
      pirq_n  = 2'b11;
      mirq    = 1'b0;
      isa_irq = IDLE_ISA;
   endtask

   task automatic all_off();
      for (int s = 0; s < 3; s++) write_reg(2'(s), 8'h80);
   endtask

   task automatic t_reset();
      pirq_n = 2'b00;
      mirq   = 1'b1;
      check("R1", IDLE_OUT);
      idle_pins();
   endtask

   task automatic t_shared();
      for (int s = 0; s < 2; s++) begin
         for (int k = 0; k < 11; k++) begin
            write_reg(2'(s), 8'(legal[k]));
            pirq_n[s] = 1'b0;
            check("R2", IDLE_OUT | bitv(legal[k]));
            pirq_n[s] = 1'b1;
            check("R2", IDLE_OUT);
         end
         write_reg(2'(s), 8'h80);
      end
   endtask

   task automatic t_board();
      for (int k = 0; k < 11; k++) begin
         write_reg(2'd2, 8'(legal[k]));
         mirq = 1'b1;
         check("R3", IDLE_OUT | bitv(legal[k]));
         mirq = 1'b0;
         check("R3", IDLE_OUT);
      end
      write_reg(2'd2, 8'h80);
   endtask

   task automatic t_disable();
      pirq_n[0] = 1'b0;
      write_reg(2'd0, 8'h85);
      check("R4", IDLE_OUT);
      write_reg(2'd0, 8'h05);
      check("R4", IDLE_OUT | bitv(5));
      write_reg(2'd0, 8'hFF);
      check("R4", IDLE_OUT);
      pirq_n[0] = 1'b1;
   endtask

   task automatic t_reserved();
      mirq = 1'b1;
      for (int k = 0; k < 5; k++) begin
         write_reg(2'd2, 8'(resv[k]));
         check("R5", IDLE_OUT);
      end
      write_reg(2'd2, 8'h0F);
      check("R5", IDLE_OUT | bitv(15));
      write_reg(2'd2, 8'h80);
      mirq = 1'b0;
   endtask

   task automatic t_upper();
      pirq_n[1] = 1'b0;
      write_reg(2'd1, 8'h7A);
      check("R6", IDLE_OUT | bitv(10));
      write_reg(2'd1, 8'h43);
      check("R6", IDLE_OUT | bitv(3));
      write_reg(2'd1, 8'h80);
      pirq_n[1] = 1'b1;
   endtask

   task automatic t_or();
      write_reg(2'd0, 8'h0B);
      write_reg(2'd1, 8'h0B);
      write_reg(2'd2, 8'h0B);
      pirq_n = 2'b00; mirq = 1'b1;
      check("R7", IDLE_OUT | bitv(11));
      pirq_n = 2'b01; mirq = 1'b0;
      check("R7", IDLE_OUT | bitv(11));
      pirq_n = 2'b11; mirq = 1'b1;
      check("R7", IDLE_OUT | bitv(11));
      mirq = 1'b0;
      check("R7", IDLE_OUT);
      isa_irq = IDLE_ISA | bitv(11);
      check("R7", IDLE_OUT | bitv(11));
      write_reg(2'd1, 8'h0C);
      pirq_n = 2'b01;
      check("R7", IDLE_OUT | bitv(11) | bitv(12));
      idle_pins();
      all_off();
   endtask

   task automatic t_pass();
      for (int b = 1; b < 16; b++) begin
         if (b != 8) begin
            isa_irq = IDLE_ISA | bitv(b);
            check("R8", IDLE_OUT | bitv(b));
         end
      end
      isa_irq = IDLE_ISA | bitv(0);
      check("R8", IDLE_OUT);
      isa_irq = 16'hFFFF;
      check("R8", 16'hFFFE);
      idle_pins();
   endtask

   task automatic t_irq8();
      isa_irq = 16'h0000;
      check("R9", 16'h0000);
      isa_irq = IDLE_ISA;
      pirq_n[0] = 1'b0;
      write_reg(2'd0, 8'h08);
      check("R9", IDLE_OUT);
      write_reg(2'd0, 8'h80);
      pirq_n[0] = 1'b1;
   endtask

   task automatic t_select();
      write_reg(2'd0, 8'h03);
      write_reg(2'd1, 8'h04);
      write_reg(2'd2, 8'h05);
      write_reg(2'd3, 8'h06);
      pirq_n = 2'b10;
      check("R10", IDLE_OUT | bitv(3));
      pirq_n = 2'b01;
      check("R10", IDLE_OUT | bitv(4));
      pirq_n = 2'b11; mirq = 1'b1;
      check("R10", IDLE_OUT | bitv(5));
      mirq = 1'b0;
      write_reg(2'd1, 8'h07);
      pirq_n = 2'b10;
      check("R10", IDLE_OUT | bitv(3));
      pirq_n = 2'b01;
      check("R10", IDLE_OUT | bitv(7));
      idle_pins();
      all_off();
   endtask

   task automatic t_timing();
      write_reg(2'd0, 8'h09);
      @(negedge clk);
      pirq_n[0] = 1'b0;
      check("R11", IDLE_OUT | bitv(9));
      isa_irq = IDLE_ISA | bitv(4);
      check("R11", IDLE_OUT | bitv(9) | bitv(4));
      isa_irq = IDLE_ISA;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h0A;
      check("R11", IDLE_OUT | bitv(9));
      @(posedge clk);
      check("R11", IDLE_OUT | bitv(10));
      @(negedge clk);
      wr_en = 1'b0;
      idle_pins();
      all_off();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shared();
      t_board();
      t_disable();
      t_reserved();
      t_upper();
      t_or();
      t_pass();
      t_irq8();
      t_select();
      t_timing();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule